// File: doc/BRIEF.md
# Shared Work RAM Ownership Controller

This block decides which of two processors, a main side and a sub side, may use a shared work RAM that is built as two equal halves. Each side writes and reads one common control word through its own write port. The control word selects one of two layouts. In the whole-RAM layout the entire memory belongs to one side at a time. Ownership changes hands through a release and reclaim handshake. In the split layout each side holds one half, and the halves are exchanged when the sub side flips its toggle bit. The main side may ask for such an exchange.

Ownership and exchange requests are kept as internal flags. The status bits seen on read-back are derived from those flags and from the current layout. They are not stored copies of written bits, so the meaning of the status bits depends on the layout. The block drives the RAM ownership and half-select outputs. It also gives a one-cycle notice whenever the mapping seen by the processors changes, so that downstream prefetch or cache logic can discard stale data.

Top module: `wram_own_ctrl`

## Requirements
- R1: After reset the main side owns the whole RAM. The layout is whole-RAM, the toggle and request flags are 0, and the priority is 0. Read-back is 0x01, main_full is 1 and map_chg is 0.
- R2: The control word has RET at bit 0, DMNA at bit 1, the layout at bit 2 (1 = split), and the priority field at bits 3 and 4. Higher bits read 0. Priority reads back as the last value the sub side wrote. Both read ports show the same word. With no write the state holds.
- R3: A sub-side write with RET=1 sets the main-owns flag. Every sub-side write copies its RET into the toggle flag.
- R4: In the whole-RAM layout, read-back RET equals the main-owns flag and read-back DMNA is its inverse.
- R5: In the split layout, main_upper equals the toggle flag and sub_upper is its inverse, while main_full and sub_full are 0. In the whole-RAM layout, exactly one of main_full and sub_full is 1, as given by the main-owns flag, and both upper selects are 0.
- R6: In the split layout, read-back RET is the toggle flag and read-back DMNA is the pending-request flag. A sub-side write that stays in the split layout and changes the toggle clears the request.
- R7: A sub-side write that changes the layout sets the request flag to 1 exactly when the write changes the toggle, and to 0 otherwise.
- R8: A main-side write with DMNA=0 while the layout is split raises the request. A main-side write with DMNA=1 clears the main-owns flag in either layout.
- R9: In the whole-RAM layout, a main-side write with DMNA=1 hands the RAM to the sub side (sub_full=1, read-back 0x02). A main-side write with DMNA=0 changes nothing.
- R10: map_chg is 1 for exactly the one cycle after a clock edge at which the outputs split_mode, main_full, sub_full, main_upper or sub_upper changed. At all other times it is 0.
- R11: When both sides write in the same cycle, the sub-side write is applied first. The main-side write is then judged against the layout and flags that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_wr | input | 1 | Sub-side write strobe |
| sub_wdata | input | DATA_W | Sub-side write word |
| sub_rdata | output | DATA_W | Control word as seen by the sub side |
| main_wr | input | 1 | Main-side write strobe |
| main_wdata | input | DATA_W | Main-side write word (only DMNA is used) |
| main_rdata | output | DATA_W | Control word as seen by the main side |
| split_mode | output | 1 | Split layout active |
| main_full | output | 1 | Main side owns the whole RAM |
| sub_full | output | 1 | Sub side owns the whole RAM |
| main_upper | output | 1 | Main side mapped to the upper half |
| sub_upper | output | 1 | Sub side mapped to the upper half |
| map_chg | output | 1 | One-cycle mapping change notice |

## Verification
Writes from the sub side and the main side can land in the same cycle. The outcome then depends on the sub write being applied first. For example, a sub write that leaves the split layout hides a main request. A sub write that flips the toggle clears a request the main write then raises again. The bench provokes such collisions in directed steps and throughout a long pseudo-random sweep of both strobes and all data bits. It judges each cycle's read-back, ownership outputs and change notice against an arithmetic model that applies the two writes in that order.

// File: rtl/wo_pkg.sv
package wo_pkg;
   // Bit positions of the control word; neighbours decode these.
   localparam int RET_POS  = 0;
   localparam int DMNA_POS = 1;
   localparam int MODE_POS = 2;
   localparam int PRIO_POS = 3;

   typedef enum logic {
      MODE_WHOLE = 1'b0,
      MODE_SPLIT = 1'b1
   } mode_e;

   typedef struct packed {
      logic split;
      logic main_full;
      logic sub_full;
      logic main_upper;
      logic sub_upper;
   } map_t;
endpackage

// File: rtl/wo_state.sv
module wo_state
   import wo_pkg::*;
#(
   parameter int   PRIO_W         = 2,
   parameter logic MAIN_OWNS_INIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sub_wr,
   input  logic              sub_ret,
   input  mode_e             sub_mode,
   input  logic [PRIO_W-1:0] sub_prio,
   input  logic              main_wr,
   input  logic              main_dmna,
   output logic              owns_q,
   output logic              tog_q,
   output logic              req_q,
   output mode_e             mode_q,
   output logic [PRIO_W-1:0] prio_q
);
   // Stage one: sub-side write applied to current state
   logic              s1_owns, s1_tog, s1_req;
   mode_e             s1_mode;
   logic [PRIO_W-1:0] s1_prio;
   // Stage two: main-side write judged against stage one
   logic              s2_owns, s2_req;

   always_comb begin
      s1_owns = owns_q;
      s1_tog  = tog_q;
      s1_req  = req_q;
      s1_mode = mode_q;
      s1_prio = prio_q;
      if (sub_wr) begin
         if (sub_ret) s1_owns = 1'b1;
         s1_tog = sub_ret;
         if (sub_mode != mode_q) begin
            s1_req = (sub_ret != tog_q);
         end else if (sub_mode == MODE_SPLIT && sub_ret != tog_q) begin
            s1_req = 1'b0;
         end
         s1_mode = sub_mode;
         s1_prio = sub_prio;
      end
   end

   always_comb begin
      s2_owns = s1_owns;
      s2_req  = s1_req;
      if (main_wr) begin
         if (main_dmna) begin
            s2_owns = 1'b0;
         end else if (s1_mode == MODE_SPLIT) begin
            s2_req = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owns_q <= MAIN_OWNS_INIT;
         tog_q  <= 1'b0;
         req_q  <= 1'b0;
         mode_q <= MODE_WHOLE;
         prio_q <= '0;
      end else begin
         owns_q <= s2_owns;
         tog_q  <= s1_tog;
         req_q  <= s2_req;
         mode_q <= s1_mode;
         prio_q <= s1_prio;
      end
   end

   // R3: RET=1 from the sub side claims the RAM unless main releases it
   a_r3_ret_claims: assert property (@(posedge clk) disable iff (!rst_n)
      sub_wr && sub_ret && !(main_wr && main_dmna) |=> owns_q);
   // R3: toggle follows the written RET
   a_r3_toggle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      sub_wr |=> tog_q == $past(sub_ret));
   // R6: a toggle flip within split clears the request
   a_r6_swap_clears: assert property (@(posedge clk) disable iff (!rst_n)
      sub_wr && !main_wr && sub_mode == MODE_SPLIT && mode_q == MODE_SPLIT
      && sub_ret != tog_q |=> !req_q);
   // R7: a layout switch raises a request only on a toggle change
   a_r7_switch_req: assert property (@(posedge clk) disable iff (!rst_n)
      sub_wr && !main_wr && sub_mode != mode_q
      |=> req_q == ($past(sub_ret) != $past(tog_q)));
   // R8 / R11: main request judged against the post-sub layout
   a_r8_request_raised: assert property (@(posedge clk) disable iff (!rst_n)
      main_wr && !main_dmna
      && ((sub_wr && sub_mode == MODE_SPLIT) || (!sub_wr && mode_q == MODE_SPLIT))
      |=> req_q);
   // R9: main release clears ownership
   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      main_wr && main_dmna |=> !owns_q);
   // R2: no write, no state change
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sub_wr && !main_wr |=> $stable(owns_q) && $stable(tog_q) && $stable(req_q)
      && $stable(mode_q) && $stable(prio_q));
endmodule

// File: rtl/wo_view.sv
module wo_view
   import wo_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PRIO_W = 2
) (
   input  logic              owns,
   input  logic              tog,
   input  logic              req,
   input  mode_e             mode,
   input  logic [PRIO_W-1:0] prio,
   output logic [DATA_W-1:0] rdata,
   output map_t              map
);
   localparam int USED_W = PRIO_POS + PRIO_W;

   logic stat_ret, stat_dmna;
   logic [USED_W-1:0] low_word;

   // Status bits are derived, their meaning set by the layout
   always_comb begin
      if (mode == MODE_SPLIT) begin
         stat_ret  = tog;
         stat_dmna = req;
      end else begin
         stat_ret  = owns;
         stat_dmna = ~owns;
      end
      low_word = {prio, mode == MODE_SPLIT, stat_dmna, stat_ret};
   end

   generate
      if (DATA_W > USED_W) begin : g_pad
         assign rdata = {{(DATA_W - USED_W){1'b0}}, low_word};
      end else begin : g_exact
         assign rdata = low_word;
      end
   endgenerate

   always_comb begin
      map = '0;
      if (mode == MODE_SPLIT) begin
         map.split      = 1'b1;
         map.main_upper = tog;
         map.sub_upper  = ~tog;
      end else begin
         map.main_full  = owns;
         map.sub_full   = ~owns;
      end
   end
endmodule

// File: rtl/wo_chg.sv
module wo_chg
   import wo_pkg::*;
#(
   parameter logic MAIN_OWNS_INIT = 1'b1,
   parameter bit   PULSE_LATE     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  map_t map_now,
   output logic pulse
);
   localparam map_t RST_MAP = '{split: 1'b0, main_full: MAIN_OWNS_INIT,
                                sub_full: ~MAIN_OWNS_INIT,
                                main_upper: 1'b0, sub_upper: 1'b0};

   map_t map_q;
   logic differ;

   always_ff @(posedge clk) begin
      if (!rst_n) map_q <= RST_MAP;
      else        map_q <= map_now;
   end

   assign differ = (map_now != map_q);

   generate
      if (PULSE_LATE) begin : g_late
         logic pulse_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= differ;
         end
         assign pulse = pulse_q;
      end else begin : g_early
         assign pulse = differ;
      end
   endgenerate
endmodule

// File: rtl/wram_own_ctrl.sv
module wram_own_ctrl
   import wo_pkg::*;
#(
   parameter int   DATA_W         = 8,
   parameter int   PRIO_W         = 2,
   parameter logic MAIN_OWNS_INIT = 1'b1,
   parameter bit   PULSE_LATE     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sub_wr,
   input  logic [DATA_W-1:0] sub_wdata,
   output logic [DATA_W-1:0] sub_rdata,
   input  logic              main_wr,
   input  logic [DATA_W-1:0] main_wdata,
   output logic [DATA_W-1:0] main_rdata,
   output logic              split_mode,
   output logic              main_full,
   output logic              sub_full,
   output logic              main_upper,
   output logic              sub_upper,
   output logic              map_chg
);
   localparam int USED_W = PRIO_POS + PRIO_W;

   generate
      if (PRIO_W < 1) begin : g_bad_prio
         $error("PRIO_W must be at least 1");
      end
      if (DATA_W < USED_W) begin : g_bad_width
         $error("DATA_W too narrow for the control word");
      end
   endgenerate

   logic              owns, tog, req;
   mode_e             mode;
   logic [PRIO_W-1:0] prio;
   logic [DATA_W-1:0] view_word;
   map_t              map;
   mode_e             sub_mode;

   assign sub_mode = mode_e'(sub_wdata[MODE_POS]);

   // Main side only uses DMNA; sub side ignores its DMNA bit
   logic unused_bits;
   assign unused_bits = ^{main_wdata, sub_wdata[DMNA_POS], sub_wdata[DATA_W-1:USED_W]};

   wo_state #(.PRIO_W(PRIO_W), .MAIN_OWNS_INIT(MAIN_OWNS_INIT)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .sub_wr    (sub_wr),
      .sub_ret   (sub_wdata[RET_POS]),
      .sub_mode  (sub_mode),
      .sub_prio  (sub_wdata[PRIO_POS +: PRIO_W]),
      .main_wr   (main_wr),
      .main_dmna (main_wdata[DMNA_POS]),
      .owns_q    (owns),
      .tog_q     (tog),
      .req_q     (req),
      .mode_q    (mode),
      .prio_q    (prio)
   );

   wo_view #(.DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_view (
      .owns  (owns),
      .tog   (tog),
      .req   (req),
      .mode  (mode),
      .prio  (prio),
      .rdata (view_word),
      .map   (map)
   );

   wo_chg #(.MAIN_OWNS_INIT(MAIN_OWNS_INIT), .PULSE_LATE(PULSE_LATE)) u_chg (
      .clk     (clk),
      .rst_n   (rst_n),
      .map_now (map),
      .pulse   (map_chg)
   );

   assign sub_rdata  = view_word;
   assign main_rdata = view_word;
   assign split_mode = map.split;
   assign main_full  = map.main_full;
   assign sub_full   = map.sub_full;
   assign main_upper = map.main_upper;
   assign sub_upper  = map.sub_upper;

   // R5: exactly one whole-RAM owner, or a complementary half split
   a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      split_mode ? (!main_full && !sub_full && (main_upper != sub_upper))
                 : ((main_full != sub_full) && !main_upper && !sub_upper));
   // R2: both ports see one word
   a_r2_same_view: assert property (@(posedge clk) disable iff (!rst_n)
      main_rdata == sub_rdata);

   generate
      if (!PULSE_LATE) begin : g_pulse_chk
         // R10: a mapping change is announced in the following cycle
         a_r10_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
            {split_mode, main_full, sub_full, main_upper, sub_upper} !=
            $past({split_mode, main_full, sub_full, main_upper, sub_upper}) |-> map_chg);
         // R10: no notice without a change
         a_r10_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
            {split_mode, main_full, sub_full, main_upper, sub_upper} ==
            $past({split_mode, main_full, sub_full, main_upper, sub_upper}) |-> !map_chg);
      end
   endgenerate
endmodule

// File: tb/wram_own_ctrl_test.sv
module wram_own_ctrl_test;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sub_wr = 1'b0, main_wr = 1'b0;
   logic [DW-1:0] sub_wdata = '0, main_wdata = '0;
   logic [DW-1:0] sub_rdata, main_rdata;
   logic split_mode, main_full, sub_full, main_upper, sub_upper, map_chg;

   always #10 clk = ~clk;

   wram_own_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .sub_wr(sub_wr), .sub_wdata(sub_wdata), .sub_rdata(sub_rdata),
      .main_wr(main_wr), .main_wdata(main_wdata), .main_rdata(main_rdata),
      .split_mode(split_mode), .main_full(main_full), .sub_full(sub_full),
      .main_upper(main_upper), .sub_upper(sub_upper), .map_chg(map_chg)
   );

   int checks = 0, fails = 0;
   bit done = 0;

   // Model state
   bit m_owns = 1, m_tog = 0, m_req = 0, m_mode = 0;
   bit [1:0] m_prio = 0;
   bit [4:0] m_map_prev, m_map_now;

   function automatic bit [4:0] model_map();
      return m_mode ? {1'b1, 1'b0, 1'b0, m_tog, ~m_tog}
                    : {1'b0, m_owns, ~m_owns, 1'b0, 1'b0};
   endfunction

   function automatic bit [7:0] model_word();
      bit r, d;
      r = m_mode ? m_tog : m_owns;
      d = m_mode ? m_req : ~m_owns;
      return {3'b000, m_prio, m_mode, d, r};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // Drive one cycle of writes, advance model (sub first, then main: R11)
   task automatic step(input bit sw, input bit [7:0] sd, input bit mw, input bit [7:0] md);
      m_map_prev = model_map();
      sub_wr = sw; sub_wdata = sd; main_wr = mw; main_wdata = md;
      if (sw) begin
         if (sd[0]) m_owns = 1;
         if (sd[2] != m_mode) m_req = (sd[0] != m_tog);
         else if (sd[2] && sd[0] != m_tog) m_req = 0;
         m_tog = sd[0]; m_mode = sd[2]; m_prio = sd[4:3];
      end
      if (mw) begin
         if (md[1]) m_owns = 0;
         else if (m_mode) m_req = 1;
      end
      m_map_now = model_map();
      @(posedge clk);
      @(negedge clk);
      sub_wr = 0; main_wr = 0;
   endtask

   task automatic check_all(input string tag);
      check({tag, " R2 R4 R6 read-back"}, main_rdata, model_word());
      check({tag, " R2 sub port"}, sub_rdata, model_word());
      check({tag, " R5 map"}, {split_mode, main_full, sub_full, main_upper, sub_upper}, m_map_now);
      check({tag, " R10 notice"}, map_chg, m_map_now != m_map_prev);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      bit [15:0] lf;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 reset word", main_rdata, 8'h01);
      check("R1 reset main_full", main_full, 1'b1);
      check("R1 reset notice", map_chg, 1'b0);
      // R9 release in whole layout
      step(0, 0, 1, 8'h02);
      check("R9 release word", main_rdata, 8'h02);
      check("R9 sub_full", sub_full, 1'b1);
      check("R10 pulse on release", map_chg, 1'b1);
      step(0, 0, 0, 0);
      check("R10 one cycle only", map_chg, 1'b0);
      step(0, 0, 1, 8'h00);
      check("R9 DMNA=0 ignored", main_rdata, 8'h02);
      // R3 reclaim with priority 2
      step(1, 8'h11, 0, 0);
      check("R3 reclaim word", main_rdata, 8'h11);
      check("R3 main_full", main_full, 1'b1);
      // R7 switch to split, toggle unchanged -> no request
      step(1, 8'h05, 0, 0);
      check("R7 switch no request", main_rdata, 8'h05);
      check("R5 main upper", {main_upper, sub_upper}, 2'b10);
      // R8 main request
      step(0, 0, 1, 8'h00);
      check("R8 request raised", main_rdata, 8'h07);
      check("R10 no pulse on request", map_chg, 1'b0);
      // R6 swap clears request
      step(1, 8'h04, 0, 0);
      check("R6 swap clears", main_rdata, 8'h04);
      check("R6 halves swapped", {main_upper, sub_upper}, 2'b01);
      // R7 switch with toggle change
      step(1, 8'h00, 0, 0);
      check("R4 whole read-back", main_rdata, 8'h01);
      step(1, 8'h05, 0, 0);
      check("R7 switch with request", main_rdata, 8'h07);
      // R11 simultaneous: swap clears, then main raises again
      step(1, 8'h04, 1, 8'h00);
      check("R11 sub then main request", main_rdata, 8'h06);
      // R11 sub leaves split, main releases
      step(1, 8'h00, 1, 8'h02);
      check("R11 sub then main release", main_rdata, 8'h02);
      check("R11 sub_full", sub_full, 1'b1);
      // R8 DMNA=1 in split clears owns, seen after returning to whole
      step(1, 8'h19, 0, 0);
      step(1, 8'h1D, 1, 8'h02);
      step(1, 8'h18, 0, 0);
      check("R8 owns cleared in split", main_rdata, 8'h1A);
      // Sweep, model-checked every cycle
      lf = 16'hACE1;
      for (int i = 0; i < 6000; i++) begin
         bit [7:0] sd, md;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         sd = lf[7:0];
         md = {lf[3:0], lf[15:12]} ^ lf[11:4];
         step(lf[8] | lf[9], sd, lf[10] & ~lf[14], md);
         check_all((lf[8] | lf[9]) && (lf[10] & ~lf[14]) ? "R11 sweep" : "sweep");
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule